// File: doc/BRIEF.md
# Cross Dot-Product Accumulate Unit

This unit takes two operands, each holding a pair of signed halfwords, and forms a crosswise dot product. The high halfword of operand A is multiplied by the low halfword of operand B, and the low halfword of A is multiplied by the high halfword of B. The two products are added at full precision and the sum is added into one of four wide accumulators. There is no saturation and there are no status flags. The arithmetic cannot raise any error condition, and the accumulator simply wraps.

A valid strobe and a 2-bit index choose which accumulator takes the update on a rising clock edge. A separate combinational read port returns any accumulator as a high word and a low word. Each word is also offered as a double-width value, sign-extended from its own top bit. The halfword width is a parameter: operands and words are two halfwords wide, and accumulators are four halfwords wide. The default is 16-bit halfwords, 32-bit words and 64-bit accumulators.

Top module: `xdot_acc`

## Requirements
- R1: The first product is signed in_a[31:16] times signed in_b[15:0], as a full 32-bit two's-complement value.
- R2: The second product is signed in_a[15:0] times signed in_b[31:16], as a full 32-bit two's-complement value.
- R3: -32768 times -32768 gives +2^30 with no overflow. The sum of the two products is kept at 33 bits, so a sum of +2^31 is preserved exactly.
- R4: The 33-bit sum is sign-extended to 64 bits and added to the selected accumulator. The result wraps modulo 2^64 (2^(4*HW) in general).
- R5: An update happens on a rising clock edge only when in_valid is 1. Only the accumulator selected by in_sel (0 to 3) changes; the other three hold their values.
- R6: A synchronous active-high reset clears all four accumulators to zero at the next rising edge.
- R7: rd_hi shows bits 63..32 and rd_lo shows bits 31..0 of the accumulator selected by rd_sel, combinationally. Reading the accumulator that is being written in the same cycle returns its value from before the edge.
- R8: rd_hi_sx and rd_lo_sx are rd_hi and rd_lo sign-extended to 64 bits, each from its own bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Apply one accumulate step at this edge |
| in_sel | input | 2 | Accumulator that receives the step |
| in_a | input | 32 | Operand A, two signed halfwords |
| in_b | input | 32 | Operand B, two signed halfwords |
| rd_sel | input | 2 | Accumulator shown on the read port |
| rd_hi | output | 32 | Upper word of the read accumulator |
| rd_lo | output | 32 | Lower word of the read accumulator |
| rd_hi_sx | output | 64 | rd_hi sign-extended from bit 31 |
| rd_lo_sx | output | 64 | rd_lo sign-extended from bit 31 |

## Verification
Each accumulator is state that nothing else overwrites. A single wrong update therefore stays on the read port from the very next cycle until reset. A step sent to the wrong index is visible in two places: as a missing sum in one accumulator and as a stray sum in another. The read index sweeps all four accumulators every few cycles, so such an error appears within a handful of cycles. A half-width sign-extension error or a dropped carry bit shows up as a word mismatch the first time the extreme halfwords meet, and a narrow instance exposes wraparound within a few hundred steps.

// File: rtl/xdot_acc.sv
module xdot_acc #(
  parameter int HW   = 16,
  parameter int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [$clog2(NACC)-1:0] in_sel,
  input  logic [2*HW-1:0]         in_a,
  input  logic [2*HW-1:0]         in_b,
  input  logic [$clog2(NACC)-1:0] rd_sel,
  output logic [2*HW-1:0]         rd_hi,
  output logic [2*HW-1:0]         rd_lo,
  output logic [4*HW-1:0]         rd_hi_sx,
  output logic [4*HW-1:0]         rd_lo_sx
);
  localparam int WW = 2 * HW;
  localparam int AW = 4 * HW;

  logic signed [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic signed [WW-1:0] prod_x, prod_y;
  logic signed [WW:0]   dotp;
  logic [AW-1:0]        acc_q [NACC];
  logic [AW-1:0]        acc_sum;
  logic [AW-1:0]        rd_word;

  assign a_hi = in_a[WW-1:HW];
  assign a_lo = in_a[HW-1:0];
  assign b_hi = in_b[WW-1:HW];
  assign b_lo = in_b[HW-1:0];

  assign prod_x = a_hi * b_lo;
  assign prod_y = a_lo * b_hi;
  assign dotp   = {prod_x[WW-1], prod_x} + {prod_y[WW-1], prod_y};

  assign acc_sum = acc_q[in_sel] + {{(AW-WW-1){dotp[WW]}}, dotp};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NACC; k++) acc_q[k] <= '0;
    end else if (in_valid) begin
      acc_q[in_sel] <= acc_sum;
    end
  end

  assign rd_word  = acc_q[rd_sel];
  assign rd_hi    = rd_word[AW-1:WW];
  assign rd_lo    = rd_word[WW-1:0];
  assign rd_hi_sx = {{WW{rd_hi[WW-1]}}, rd_hi};
  assign rd_lo_sx = {{WW{rd_lo[WW-1]}}, rd_lo};

  // independent wide-arithmetic view of the step, used only by the checks
  logic signed [AW-1:0] wx_ahi, wx_alo, wx_bhi, wx_blo, chk_dot;
  assign wx_ahi  = AW'(a_hi);
  assign wx_alo  = AW'(a_lo);
  assign wx_bhi  = AW'(b_hi);
  assign wx_blo  = AW'(b_lo);
  assign chk_dot = wx_ahi * wx_blo + wx_alo * wx_bhi;

  localparam logic [HW-1:0] HMIN = {1'b1, {(HW-1){1'b0}}};

  always_comb begin
    if (a_hi == HMIN && b_lo == HMIN)
      p_min_square_r3: assert (prod_x == WW'(1) << (WW-2));
    if (!(dotp[WW] == dotp[WW-1]))
      p_dot_span_r3: assert (dotp == (WW+1)'(1) << (WW-1));
  end

  for (genvar k = 0; k < NACC; k++) begin : g_chk
    p_clear_r6: assert property (@(posedge clk)
      rst |=> (acc_q[k] == '0));

    p_hold_other_r5: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_sel == k) |=> $stable(acc_q[k]));

    p_step_sum_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_sel == k) |=> (acc_q[k] == $past(acc_q[k] + AW'(chk_dot))));
  end
endmodule

// File: tb/sim_xdot_acc.sv
`timescale 1ns/100ps
module sim_xdot_acc;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, in_valid;
  logic [1:0]  in_sel, rd_sel;
  logic [31:0] in_a, in_b;
  logic [31:0] rd_hi, rd_lo;
  logic [63:0] rd_hi_sx, rd_lo_sx;
  logic [7:0]  n_a, n_b, n_hi, n_lo;
  logic [15:0] n_hi_sx, n_lo_sx;

  xdot_acc u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_a(in_a), .in_b(in_b), .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_hi_sx(rd_hi_sx), .rd_lo_sx(rd_lo_sx));

  // narrow instance: 4-bit halfwords, 16-bit accumulators, reaches wraparound fast
  assign n_a = {in_a[31:28], in_a[15:12]};
  assign n_b = {in_b[31:28], in_b[15:12]};
  xdot_acc #(.HW(4)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_a(n_a), .in_b(n_b), .rd_sel(rd_sel), .rd_hi(n_hi), .rd_lo(n_lo),
    .rd_hi_sx(n_hi_sx), .rd_lo_sx(n_lo_sx));

  longint m0 [4];
  int     m1 [4];
  int     n_cmp = 0, n_bad = 0, n_wrap = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [1:0] s,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] rs, input string tag);
    longint d0, old;
    int d1, nxt;
    @(negedge clk);
    rst = r; in_valid = v; in_sel = s; in_a = a; in_b = b; rd_sel = rs;
    #1;
    // R7: read port shows the state from before this edge
    chk(rd_hi == m0[rs][63:32], {tag, " R7 hi"}, longint'(rd_hi), longint'(m0[rs][63:32]));
    chk(rd_lo == m0[rs][31:0],  {tag, " R7 lo"}, longint'(rd_lo), longint'(m0[rs][31:0]));
    chk(rd_hi_sx == longint'($signed(m0[rs][63:32])), {tag, " R8 hi_sx"},
        rd_hi_sx, longint'($signed(m0[rs][63:32])));
    chk(rd_lo_sx == longint'($signed(m0[rs][31:0])), {tag, " R8 lo_sx"},
        rd_lo_sx, longint'($signed(m0[rs][31:0])));
    chk({n_hi, n_lo} == m1[rs][15:0], {tag, " R4 narrow"},
        longint'({n_hi, n_lo}), longint'(m1[rs][15:0]));
    if (r) begin
      for (int k = 0; k < 4; k++) begin m0[k] = 0; m1[k] = 0; end
    end else if (v) begin
      d0 = longint'($signed(a[31:16])) * longint'($signed(b[15:0]))
         + longint'($signed(a[15:0])) * longint'($signed(b[31:16]));
      m0[s] = m0[s] + d0;
      d1 = int'($signed(n_a[7:4])) * int'($signed(n_b[3:0]))
         + int'($signed(n_a[3:0])) * int'($signed(n_b[7:4]));
      old = longint'($signed(m1[s][15:0]));
      nxt = (m1[s] + d1) & 32'hFFFF;
      if (d1 > 0 && old + d1 > 32767) n_wrap++;
      m1[s] = nxt;
    end
  endtask

  function automatic logic [15:0] pick_half();
    case ($urandom_range(0, 4))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  bit finished = 0;

  initial begin
    for (int k = 0; k < 4; k++) begin m0[k] = 0; m1[k] = 0; end
    rst = 1; in_valid = 0; in_sel = 0; in_a = 0; in_b = 0; rd_sel = 0;
    repeat (2) @(posedge clk);
    // R6: reset state of every accumulator
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 2'(k), "R6 reset");
    // R1: only the high(A) x low(B) product is nonzero
    step(0, 1, 1, 32'h0002_0000, 32'h0000_0003, 1, "R1");
    step(0, 0, 0, 0, 0, 1, "R1 result");
    // R2: only the low(A) x high(B) product is nonzero, negative operand
    step(0, 1, 2, 32'h0000_FFFB, 32'h0007_0000, 2, "R2");
    step(0, 0, 0, 0, 0, 2, "R2 result");
    // R3: both products equal +2^30, sum +2^31 must not turn negative
    step(0, 1, 0, 32'h8000_8000, 32'h8000_8000, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R3 result");
    chk(rd_lo == 32'h8000_0000 && rd_hi == 32'h0, "R3 sum", longint'({rd_hi, rd_lo}), 64'h8000_0000);
    chk(rd_lo_sx == 64'hFFFF_FFFF_8000_0000, "R8 lo_sx negative word", rd_lo_sx, 64'hFFFF_FFFF_8000_0000);
    // R5: valid low must change nothing, and untouched accumulators keep values
    step(0, 0, 0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, "R5 idle");
    for (int k = 0; k < 4; k++) step(0, 0, 3, 32'h1234_5678, 32'h1, 2'(k), "R5 hold");
    // R7: same-cycle read of the written accumulator returns the old value
    step(0, 1, 3, 32'h0001_0001, 32'h0001_0001, 3, "R7 same-cycle");
    step(0, 0, 0, 0, 0, 3, "R7 after write");
    // random operands with extreme lanes on all accumulators
    for (int i = 0; i < 3000; i++)
      step(0, 1'($urandom_range(0, 3) != 0), 2'($urandom), {pick_half(), pick_half()},
           {pick_half(), pick_half()}, 2'($urandom), "R1 R2 R4 random");
    // R6: mid-run reset
    step(1, 1, 0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, "R6 pre");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 2'(k), "R6 mid-run clear");
    // R4: drive the narrow instance past its most positive value
    for (int i = 0; i < 600; i++)
      step(0, 1, 0, 32'h8000_8000, 32'h8000_8000, 2'(i), "R4 wrap");
    step(0, 0, 0, 0, 0, 0, "R4 wrap final");
    chk(n_wrap > 0, "R4 wraparound reached", longint'(n_wrap), 1);
    // R4: negative steps on the wide instance
    for (int i = 0; i < 50; i++)
      step(0, 1, 1, 32'h8000_7FFF, 32'h8000_7FFF, 1, "R4 negative");
    step(0, 0, 0, 0, 0, 1, "R4 negative final");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule